// File: doc/BRIEF.md
# Accumulator Machine Instruction Sequencer

This block is the control and register core of a minimal accumulator computer that shares one memory between instructions and data. A three-bit timing counter walks each instruction through fixed states: fetch the word at the program counter, decode it, then run a short execute phase. The execute phase either loads the accumulator from memory or writes the accumulator back to memory. The core holds the program counter, the address register, the instruction register, a pointer register, the accumulator and the indirect flag.

Each instruction word is 16 bits. Bit 15 selects indirect addressing, bits 14..12 hold the operation code and bits 11..0 hold an address. When the indirect flag is set, the addressed word is read as a pointer, and its low twelve bits become the operand address. This costs two more timing states. Operation codes other than load and store change nothing and end after the decode state. The memory is read combinationally from the address output, and the core makes one access per timing state.

Top module: `acc_seq_top`

## Requirements
- R1: While reset is asserted and until the first instruction starts, mem_addr is 0, mem_we is 0, acc_value is 0 and at_fetch is 1. The first instruction is fetched from address 0.
- R2: Instructions are fetched from consecutive addresses. In the cycle after the fetch-start state (at_fetch=1), mem_addr equals the address of the instruction that is being fetched.
- R3: Bit 15 of the instruction is the indirect flag, bits 14..12 are the opcode and bits 11..0 are the address. After the decode state, mem_addr holds bits 11..0 of the instruction.
- R4: Opcode 2 with bit 15 clear (direct load) loads acc_value from memory at the address field. The instruction takes 4 cycles.
- R5: Opcode 2 with bit 15 set (indirect load) reads a pointer word, then loads acc_value from the address that the pointer gives. The instruction takes 6 cycles.
- R6: Opcode 3 with bit 15 clear (direct store) raises mem_we for one cycle in its fourth state, with mem_wdata equal to acc_value and mem_addr equal to the address field. The instruction takes 4 cycles.
- R7: Opcode 3 with bit 15 set (indirect store) writes acc_value to the address that the pointer word gives. The write happens in the sixth state and the instruction takes 6 cycles.
- R8: Every opcode other than 2 and 3 takes 4 cycles whatever bit 15 holds. It leaves acc_value unchanged and does not write memory.
- R9: mem_we is high for exactly one cycle per store, and the cycle after it is a fetch start.
- R10: Only bits 11..0 of a pointer word form the operand address. Its bits 15..12 are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mem_addr | output | 12 | Memory address, equal to the address register |
| mem_rdata | input | 16 | Memory read data, valid in the same cycle as mem_addr |
| mem_wdata | output | 16 | Memory write data, equal to the accumulator |
| mem_we | output | 1 | Memory write strobe |
| at_fetch | output | 1 | High in the first timing state of each instruction |
| acc_value | output | 16 | Current accumulator contents |

## Verification
The program mixes direct and indirect loads and stores with operation codes 0, 1, 4 and 7. One of those no-op words has bit 15 set, which shows that the extra pointer states belong only to memory-reference instructions. The pointer words carry nonzero upper bits, so a design that used more than the low twelve bits would write to or read from the wrong address. One load reads a zero word, which tells a real load apart from an accumulator that simply holds its old value. The bench measures the cycle count of every instruction, the fetch address and the accumulator at each instruction boundary. Together these separate a correct 4-state or 6-state path from a skipped or extra state.

// File: rtl/acc_seq_pkg.sv
package acc_seq_pkg;

  parameter int unsigned WORD_W_D = 16;
  parameter int unsigned ADDR_W_D = 12;
  localparam int unsigned SC_W    = 3;

  typedef enum logic [SC_W-1:0] {
    ST_T0 = 3'd0,
    ST_T1 = 3'd1,
    ST_T2 = 3'd2,
    ST_T3 = 3'd3,
    ST_T4 = 3'd4,
    ST_T5 = 3'd5
  } tstate_e;

  localparam int unsigned OPC_LOAD  = 2;
  localparam int unsigned OPC_STORE = 3;

endpackage

// File: rtl/acc_seq_rst_sync.sv
module acc_seq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= sync_d;
  end

  assign rst_n_out = sync_q[STAGES-1];

endmodule

// File: rtl/acc_seq_timer.sv
module acc_seq_timer
  import acc_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    step,
  input  logic    restart,
  output tstate_e state
);

  tstate_e state_q;
  tstate_e state_d;

  always_comb begin
    state_d = state_q;
    if (restart) begin
      state_d = ST_T0;
    end else if (step) begin
      if (state_q == ST_T5) state_d = ST_T0;
      else                  state_d = tstate_e'(state_q + 3'd1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_T0;
    else        state_q <= state_d;
  end

  assign state = state_q;

  // R5
  sc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_q inside {ST_T0, ST_T1, ST_T2, ST_T3, ST_T4, ST_T5});

  // R8
  sc_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (state_q == ST_T0));

endmodule

// File: rtl/acc_seq_opdec.sv
module acc_seq_opdec #(
  parameter int unsigned OPC_W = 3
) (
  input  logic [OPC_W-1:0]       opcode,
  output logic [(1<<OPC_W)-1:0]  dec
);

  localparam int unsigned NUM_OPS = 1 << OPC_W;

  for (genvar k = 0; k < NUM_OPS; k++) begin : g_line
    assign dec[k] = (opcode == OPC_W'(k));
  end

endmodule

// File: rtl/acc_seq_datapath.sv
module acc_seq_datapath #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] rdata,
  input  logic              ar_from_pc,
  input  logic              ar_from_ir,
  input  logic              ar_from_ptr,
  input  logic              ir_load,
  input  logic              pc_step,
  input  logic              ptr_load,
  input  logic              acc_load,
  input  logic              ind_load,
  output logic [ADDR_W-1:0] ar,
  output logic [ADDR_W-1:0] pc,
  output logic [WORD_W-1:0] ir,
  output logic [WORD_W-1:0] acc,
  output logic              ind_flag
);

  localparam int unsigned IND_BIT = WORD_W - 1;

  logic [ADDR_W-1:0] ar_q, ar_d;
  logic [ADDR_W-1:0] pc_q, pc_d;
  logic [WORD_W-1:0] ir_q, ir_d;
  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic [WORD_W-1:0] acc_q, acc_d;
  logic              ind_q, ind_d;

  always_comb begin
    ar_d = ar_q;
    if (ar_from_pc)       ar_d = pc_q;
    else if (ar_from_ir)  ar_d = ir_q[ADDR_W-1:0];
    else if (ar_from_ptr) ar_d = ptr_q;
  end

  always_comb begin
    pc_d  = pc_step  ? pc_q + ADDR_W'(1) : pc_q;
    ir_d  = ir_load  ? rdata             : ir_q;
    ptr_d = ptr_load ? rdata[ADDR_W-1:0] : ptr_q;
    acc_d = acc_load ? rdata             : acc_q;
    ind_d = ind_load ? ir_q[IND_BIT]     : ind_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ar_q  <= '0;
      pc_q  <= '0;
      ir_q  <= '0;
      ptr_q <= '0;
      acc_q <= '0;
      ind_q <= 1'b0;
    end else begin
      ar_q  <= ar_d;
      pc_q  <= pc_d;
      ir_q  <= ir_d;
      ptr_q <= ptr_d;
      acc_q <= acc_d;
      ind_q <= ind_d;
    end
  end

  assign ar       = ar_q;
  assign pc       = pc_q;
  assign ir       = ir_q;
  assign acc      = acc_q;
  assign ind_flag = ind_q;

  // R2
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_step |=> (pc_q == $past(pc_q) + ADDR_W'(1)));

  // R10
  ptr_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_load ##1 ar_from_ptr) |=> (ar_q == $past(rdata[ADDR_W-1:0], 2)));

  // R3
  ind_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ind_load |=> (ind_q == $past(ir_q[IND_BIT])));

endmodule

// File: rtl/acc_seq_top.sv
module acc_seq_top
  import acc_seq_pkg::*;
#(
  parameter int unsigned WORD_W = WORD_W_D,
  parameter int unsigned ADDR_W = ADDR_W_D
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic [WORD_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic              at_fetch,
  output logic [WORD_W-1:0] acc_value
);

  localparam int unsigned OPC_W   = WORD_W - 1 - ADDR_W;
  localparam int unsigned NUM_OPS = 1 << OPC_W;
  localparam logic [NUM_OPS-1:0] MEMREF_MASK =
    (NUM_OPS'(1) << OPC_LOAD) | (NUM_OPS'(1) << OPC_STORE);

  logic              rst_n_sync;
  tstate_e           state;
  logic              sc_step, sc_restart;
  logic              ar_from_pc, ar_from_ir, ar_from_ptr;
  logic              ir_load, pc_step, ptr_load, acc_load, ind_load;
  logic              we_d;
  logic [ADDR_W-1:0] ar, pc;
  logic [WORD_W-1:0] ir, acc;
  logic              ind_flag;
  logic [NUM_OPS-1:0] dec;
  logic              is_load, is_store, other_op;

  acc_seq_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_sync)
  );

  acc_seq_timer u_timer (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .step    (sc_step),
    .restart (sc_restart),
    .state   (state)
  );

  acc_seq_opdec #(.OPC_W(OPC_W)) u_opdec (
    .opcode (ir[WORD_W-2:ADDR_W]),
    .dec    (dec)
  );

  acc_seq_datapath #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_dp (
    .clk         (clk),
    .rst_n       (rst_n_sync),
    .rdata       (mem_rdata),
    .ar_from_pc  (ar_from_pc),
    .ar_from_ir  (ar_from_ir),
    .ar_from_ptr (ar_from_ptr),
    .ir_load     (ir_load),
    .pc_step     (pc_step),
    .ptr_load    (ptr_load),
    .acc_load    (acc_load),
    .ind_load    (ind_load),
    .ar          (ar),
    .pc          (pc),
    .ir          (ir),
    .acc         (acc),
    .ind_flag    (ind_flag)
  );

  assign is_load  = dec[OPC_LOAD];
  assign is_store = dec[OPC_STORE];
  assign other_op = |(dec & ~MEMREF_MASK);

  always_comb begin
    sc_step     = 1'b0;
    sc_restart  = 1'b0;
    ar_from_pc  = 1'b0;
    ar_from_ir  = 1'b0;
    ar_from_ptr = 1'b0;
    ir_load     = 1'b0;
    pc_step     = 1'b0;
    ptr_load    = 1'b0;
    acc_load    = 1'b0;
    ind_load    = 1'b0;
    we_d        = 1'b0;
    case (state)
      ST_T0: begin
        ar_from_pc = 1'b1;
        sc_step    = 1'b1;
      end
      ST_T1: begin
        ir_load = 1'b1;
        pc_step = 1'b1;
        sc_step = 1'b1;
      end
      ST_T2: begin
        ind_load   = 1'b1;
        ar_from_ir = 1'b1;
        sc_step    = 1'b1;
      end
      ST_T3: begin
        if (other_op) begin
          sc_restart = 1'b1;
        end else if (ind_flag) begin
          ptr_load = 1'b1;
          sc_step  = 1'b1;
        end else begin
          acc_load   = is_load;
          we_d       = is_store;
          sc_restart = 1'b1;
        end
      end
      ST_T4: begin
        if (other_op) begin
          sc_restart = 1'b1;
        end else begin
          ar_from_ptr = 1'b1;
          sc_step     = 1'b1;
        end
      end
      ST_T5: begin
        acc_load   = is_load;
        we_d       = is_store;
        sc_restart = 1'b1;
      end
      default: begin
        sc_restart = 1'b1;
      end
    endcase
  end

  assign mem_addr  = ar;
  assign mem_wdata = acc;
  assign mem_we    = we_d;
  assign at_fetch  = (state == ST_T0);
  assign acc_value = acc;

  // R2
  fetch_addr_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (state == ST_T0) |=> (mem_addr == $past(pc)));

  // R3
  decode_addr_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (state == ST_T2) |=> (mem_addr == $past(ir[ADDR_W-1:0])));

  // R4
  direct_load_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (state == ST_T3 && is_load && !ind_flag) |=> (acc_value == $past(mem_rdata) && at_fetch));

  // R8
  other_keep_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (state == ST_T3 && other_op) |=> (acc_value == $past(acc_value) && at_fetch));

  // R8
  other_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    other_op |-> !mem_we);

  // R9
  we_single_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    mem_we |=> (!mem_we && at_fetch));

  // R6
  store_data_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    mem_we |-> (mem_wdata == acc_value && is_store));

endmodule

// File: tb/acc_seq_top_tb.sv
module acc_seq_top_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] mem_addr;
  logic [15:0] mem_rdata;
  logic [15:0] mem_wdata;
  logic        mem_we;
  logic        at_fetch;
  logic [15:0] acc_value;

  logic [15:0] mem [256];

  typedef struct {
    int          pc;
    int          cycles;
    logic [15:0] acc;
    string       tag;
  } instr_item_t;

  typedef struct {
    logic [11:0] addr;
    logic [15:0] data;
    string       tag;
  } wr_item_t;

  instr_item_t exp_instr[$];
  wr_item_t    exp_wr[$];

  int n_checks = 0;
  int n_errors = 0;
  bit run      = 1'b0;
  int cnt      = 0;
  bit prev_we  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_seq_top u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_addr  (mem_addr),
    .mem_rdata (mem_rdata),
    .mem_wdata (mem_wdata),
    .mem_we    (mem_we),
    .at_fetch  (at_fetch),
    .acc_value (acc_value)
  );

  assign mem_rdata = mem[mem_addr[7:0]];

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic push_instr(input int pc, input int cycles,
                            input logic [15:0] acc, input string tag);
    instr_item_t it;
    it.pc = pc; it.cycles = cycles; it.acc = acc; it.tag = tag;
    exp_instr.push_back(it);
  endtask

  task automatic push_wr(input logic [11:0] addr, input logic [15:0] data,
                         input string tag);
    wr_item_t w;
    w.addr = addr; w.data = data; w.tag = tag;
    exp_wr.push_back(w);
  endtask

  // Monitor: pops expected items as the design finishes instructions and writes.
  always @(negedge clk) begin
    if (run) begin
      if (mem_we) begin
        check(!prev_we, "R9", "write strobe longer than one cycle", 1, 0);
        if (exp_wr.size() == 0) begin
          check(1'b0, "R8", "unexpected write at address", int'(mem_addr), 0);
        end else begin
          wr_item_t w;
          w = exp_wr.pop_front();
          check(mem_addr == w.addr, w.tag, "write address", int'(mem_addr), int'(w.addr));
          check(mem_wdata == w.data, w.tag, "write data", int'(mem_wdata), int'(w.data));
        end
      end
      prev_we = mem_we;
      if (at_fetch) begin
        if (cnt > 1 && exp_instr.size() > 0) begin
          instr_item_t it;
          it = exp_instr.pop_front();
          check(cnt == it.cycles, it.tag, "instruction cycles", cnt, it.cycles);
          check(acc_value == it.acc, it.tag, "accumulator", int'(acc_value), int'(it.acc));
        end
        cnt = 1;
      end else begin
        cnt++;
        if (cnt == 2 && exp_instr.size() > 0)
          check(mem_addr == 12'(exp_instr[0].pc), "R2", "fetch address",
                int'(mem_addr), exp_instr[0].pc);
      end
    end
  end

  initial begin
    bit timed_out;
    timed_out = 1'b0;
    for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
    // program
    mem[0]  = 16'h2040;  // load direct 0x040
    mem[1]  = 16'h3050;  // store direct 0x050
    mem[2]  = 16'h0041;  // opcode 0
    mem[3]  = 16'h7055;  // opcode 7
    mem[4]  = 16'hA041;  // load indirect via 0x041
    mem[5]  = 16'hB042;  // store indirect via 0x042
    mem[6]  = 16'h3051;  // store direct 0x051
    mem[7]  = 16'h9044;  // opcode 1 with indirect bit
    mem[8]  = 16'h2043;  // load direct 0x043 (zero)
    mem[9]  = 16'h3052;  // store direct 0x052
    mem[10] = 16'h4000;  // opcode 4
    // data
    mem[8'h40] = 16'h1234;
    mem[8'h41] = 16'hF060;  // pointer, upper bits set (R10)
    mem[8'h42] = 16'hE070;  // pointer, upper bits set (R10)
    mem[8'h43] = 16'h0000;
    mem[8'h60] = 16'hBEEF;

    push_instr(0,  4, 16'h1234, "R4");
    push_instr(1,  4, 16'h1234, "R6");
    push_wr(12'h050, 16'h1234, "R6");
    push_instr(2,  4, 16'h1234, "R8");
    push_instr(3,  4, 16'h1234, "R8");
    push_instr(4,  6, 16'hBEEF, "R5");
    push_instr(5,  6, 16'hBEEF, "R7");
    push_wr(12'h070, 16'hBEEF, "R10");
    push_instr(6,  4, 16'hBEEF, "R6");
    push_wr(12'h051, 16'hBEEF, "R6");
    push_instr(7,  4, 16'hBEEF, "R8");
    push_instr(8,  4, 16'h0000, "R4");
    push_instr(9,  4, 16'h0000, "R6");
    push_wr(12'h052, 16'h0000, "R6");
    push_instr(10, 4, 16'h0000, "R8");

    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check(mem_addr == 12'h000, "R1", "reset mem_addr", int'(mem_addr), 0);
    check(mem_we == 1'b0, "R1", "reset mem_we", int'(mem_we), 0);
    check(acc_value == 16'h0000, "R1", "reset acc_value", int'(acc_value), 0);
    check(at_fetch == 1'b1, "R1", "reset at_fetch", int'(at_fetch), 1);
    rst_n = 1'b1;
    run   = 1'b1;

    for (int c = 0; c < 2000 && exp_instr.size() > 0; c++) @(posedge clk);
    if (exp_instr.size() > 0) begin
      timed_out = 1'b1;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: %0d instructions left, expected 0", exp_instr.size());
    end
    run = 1'b0;
    @(negedge clk);
    if (!timed_out) begin
      check(exp_wr.size() == 0, "R6", "pending writes", exp_wr.size(), 0);
      check(mem[8'h50] == 16'h1234, "R6", "memory at 0x050", int'(mem[8'h50]), 'h1234);
      check(mem[8'h70] == 16'hBEEF, "R7", "memory at 0x070", int'(mem[8'h70]), 'hBEEF);
      check(mem[8'h55] == 16'h0000, "R8", "memory at 0x055", int'(mem[8'h55]), 0);
      check(mem[8'h40] == 16'h1234, "R8", "memory at 0x040", int'(mem[8'h40]), 'h1234);
    end
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule